// File: doc/BRIEF.md
# CAN Message Buffer Bank with Acceptance Filtering and Transmit Arbitration

This block is the buffer side of a CAN controller. It keeps fifteen message buffers. Each buffer holds an identifier, a 32-bit payload, a remote flag, a 16-bit time stamp and a control word. Software marks every buffer as a receiver or a transmitter. A bit-level bus engine outside this block hands over each received frame as a one-cycle identifier/data strobe. The block compares the identifier against the receive buffers through two acceptance masks and writes the frame into the chosen buffer. On the transmit side it offers the engine the pending transmit buffer that wins a programmable priority contest. The engine reports completion with a one-cycle pulse.

Two remote-frame automations exist. A transmitter armed for auto-reply is scheduled by itself when a remote frame with its identifier arrives. A buffer that sends a remote frame can fall back to receive mode so that it can catch the answer. A free-running counter stamps every stored or completed frame. A 16-bit word-addressed port with byte enables gives the CPU single-cycle access to every field. Reads are combinational.

Top module: `can_mb_top`

## Requirements
- R1: After reset every buffer is an empty receiver: control word 0, identifier 0, payload 0. Both masks are all ones, the counter starts at 0, and tx_valid and rx_stored are low.
- R2: The CPU address is {slot[3:0], word[2:0]}. Slots 0–14 are buffers and slot 15 holds the global registers. Buffer words: 0 = id[15:0], 1 = {ide at bit 15, id[28:16] at bits 12:0}, 2 = data[15:0], 3 = data[31:16], 4 = time stamp (read-only), 5 = control. Global words: 0/1 = shared mask, 2/3 = basic-buffer mask (same layout as buffer words 0/1 without ide), 4 = live counter (read-only). cpu_be[0] enables bits 7:0 and cpu_be[1] enables bits 15:8; disabled bytes keep their value.
- R3: Control word layout: bits 1:0 = state (0 empty/idle, 1 full, 2 transmit request), bit 2 = direction (1 transmit), bit 3 = remote flag, bits 7:4 = priority, bit 8 = revert-to-receive after a remote send, bit 9 = auto-reply.
- R4: A frame matches a receive buffer in state 0 when the ide bits are equal and every identifier bit whose mask bit is 1 is equal. A mask bit of 0 means don't care. For standard frames (ide=0) only id[10:0] is compared.
- R5: Buffers 0–13 use the shared mask. When several of them match, the lowest index wins, and full buffers are skipped.
- R6: Buffer 14 uses its own mask and takes a frame only when no buffer among 0–13 matches.
- R7: A stored frame writes its identifier, ide, payload and remote flag, sets state 1, and stamps the counter value of the storing cycle. A frame that finds no buffer changes nothing.
- R8: One cycle after a frame is stored, rx_stored is high for exactly one cycle and rx_slot gives the buffer.
- R9: Among transmitters in state 2, the lowest priority value wins and ties go to the lower index. tx_valid, tx_slot and the tx fields show the winner.
- R10: tx_done while tx_valid is high returns the offered buffer to state 0 and stamps the counter.
- R11: If the completed buffer had the remote flag and revert bit set, it becomes a receiver in state 0 and can accept frames.
- R12: A received remote frame whose ide and full identifier equal those of an auto-reply transmitter sets that transmitter to state 2 and is not stored. A remote frame without such a match is stored like any other frame.
- R13: The counter adds one every cycle and wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Write strobe |
| cpu_be | input | 2 | Byte enables |
| cpu_addr | input | 7 | {slot, word} address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Combinational read data |
| rx_valid | input | 1 | Received frame strobe |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received frame is extended |
| rx_rtr | input | 1 | Received frame is remote |
| rx_data | input | 32 | Received payload |
| rx_stored | output | 1 | Frame was stored last cycle |
| rx_slot | output | 4 | Buffer that took it |
| tx_valid | output | 1 | A transmit buffer is offered |
| tx_slot | output | 4 | Offered buffer |
| tx_id | output | 29 | Offered identifier |
| tx_ide | output | 1 | Offered frame is extended |
| tx_rtr | output | 1 | Offered frame is remote |
| tx_data | output | 32 | Offered payload |
| tx_done | input | 1 | Engine finished the offered frame |

## Verification
The bench sends a standard frame with high identifier bits set and a "standard" identifier inside an extended frame. A filter that compares all 29 bits, or ignores ide, would store the first in the wrong place and take the second. It fills buffers 0, 1 and 14 in turn with the same identifier and then sends one more. A wrong fallback order shows up as the wrong slot, and a design that overwrites a full buffer reports a store where none should happen. On transmit it pairs two equal priorities behind a numerically lower index that has a worse priority. An inverted comparison or a wrong tie-break shows up in tx_slot. The remote-frame checks show whether the reply frame leaks into a receive buffer and whether a reverted buffer really accepts frames again.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 4;

  typedef enum logic [1:0] {
    MB_EMPTY = 2'd0,
    MB_FULL  = 2'd1,
    MB_TXREQ = 2'd2,
    MB_RSVD  = 2'd3
  } mb_state_e;

  // identifier compare under a care mask; standard frames look at the low bits only
  function automatic logic id_hit(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b,
                                  input logic [ID_W-1:0] care, input logic ext);
    logic [ID_W-1:0] m;
    m = ext ? care : {{(ID_W-STD_W){1'b0}}, care[STD_W-1:0]};
    return ((a ^ b) & m) == '0;
  endfunction

  function automatic logic [15:0] byte_merge(input logic [15:0] old_w, input logic [15:0] new_w,
                                             input logic [1:0] be);
    logic [15:0] keep;
    keep = {{8{be[1]}}, {8{be[0]}}};
    return (new_w & keep) | (old_w & ~keep);
  endfunction
endpackage

// File: rtl/can_mb_tstamp.sv
module can_mb_tstamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts_now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_now <= '0;
    else        ts_now <= ts_now + 1'b1;
  end

  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts_now == $past(ts_now) + 1'b1); // R13
endmodule

// File: rtl/can_mb_accept.sv
module can_mb_accept
  import can_mb_pkg::*;
#(
  parameter int NBUF = 15,
  localparam int SLOT_W = $clog2(NBUF + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic [ID_W-1:0]            rx_id,
  input  logic                       rx_ide,
  input  logic                       rx_rtr,
  input  logic [NBUF-1:0][ID_W-1:0]  mb_id,
  input  logic [NBUF-1:0]            mb_ide,
  input  logic [NBUF-1:0]            mb_dir,
  input  logic [NBUF-1:0][1:0]       mb_state,
  input  logic [NBUF-1:0]            mb_arep,
  input  logic [ID_W-1:0]            gmask,
  input  logic [ID_W-1:0]            bmask,
  output logic [NBUF-1:0]            store_vec,
  output logic [SLOT_W-1:0]          store_slot,
  output logic [NBUF-1:0]            reply_vec
);
  logic [NBUF-1:0] hit;
  logic [NBUF-1:0] rep;
  logic            found;
  logic [SLOT_W-1:0] pick;

  for (genvar g = 0; g < NBUF; g++) begin : g_flt
    logic [ID_W-1:0] care;
    if (g == NBUF - 1) begin : g_basic
      assign care = bmask;
    end else begin : g_shared
      assign care = gmask;
    end
    assign hit[g] = rx_valid && !mb_dir[g] && (mb_state[g] == MB_EMPTY) &&
                    (mb_ide[g] == rx_ide) && id_hit(rx_id, mb_id[g], care, rx_ide);
    assign rep[g] = rx_valid && rx_rtr && mb_dir[g] && mb_arep[g] &&
                    (mb_ide[g] == rx_ide) && id_hit(rx_id, mb_id[g], {ID_W{1'b1}}, rx_ide);
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NBUF - 1; i++) begin
      if (hit[i] && !found) begin
        found = 1'b1;
        pick  = SLOT_W'(i);
      end
    end
    if (!found && hit[NBUF-1]) begin
      found = 1'b1;
      pick  = SLOT_W'(NBUF - 1);
    end
  end

  assign store_slot = pick;
  assign store_vec  = (found && !(|rep)) ? (NBUF'(1) << pick) : '0;
  assign reply_vec  = rep;

  AST_STORE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store_vec)); // R5
  AST_BASIC_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    store_vec[NBUF-1] |-> !(|hit[NBUF-2:0])); // R6
endmodule

// File: rtl/can_mb_txarb.sv
module can_mb_txarb
  import can_mb_pkg::*;
#(
  parameter int NBUF = 15,
  localparam int SLOT_W = $clog2(NBUF + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NBUF-1:0]              pend,
  input  logic [NBUF-1:0][PRIO_W-1:0]  prio,
  output logic                         valid,
  output logic [SLOT_W-1:0]            slot
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    valid = 1'b0;
    slot  = '0;
    best  = '1;
    for (int i = 0; i < NBUF; i++) begin
      if (pend[i] && (!valid || prio[i] < best)) begin
        valid = 1'b1;
        slot  = SLOT_W'(i);
        best  = prio[i];
      end
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_chk
    AST_ARB_NO_BETTER: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && pend[g]) |-> prio[g] >= prio[slot]); // R9
    AST_ARB_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && pend[g] && SLOT_W'(g) < slot) |-> prio[g] > prio[slot]); // R9
  end
endmodule

// File: rtl/can_mb_top.sv
module can_mb_top
  import can_mb_pkg::*;
#(
  parameter int NBUF = 15,
  parameter int TS_W = 16,
  localparam int SLOT_W = $clog2(NBUF + 1),
  localparam int AW = SLOT_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_be,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_ide,
  input  logic              rx_rtr,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_stored,
  output logic [SLOT_W-1:0] rx_slot,
  output logic              tx_valid,
  output logic [SLOT_W-1:0] tx_slot,
  output logic [ID_W-1:0]   tx_id,
  output logic              tx_ide,
  output logic              tx_rtr,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_done
);
  localparam int GLOBAL = (1 << SLOT_W) - 1;

  logic [NBUF-1:0][ID_W-1:0]   mb_id;
  logic [NBUF-1:0]             mb_ide;
  logic [NBUF-1:0][DATA_W-1:0] mb_data;
  logic [NBUF-1:0][TS_W-1:0]   mb_ts;
  logic [NBUF-1:0][1:0]        mb_state;
  logic [NBUF-1:0]             mb_dir;
  logic [NBUF-1:0]             mb_rtr;
  logic [NBUF-1:0][PRIO_W-1:0] mb_prio;
  logic [NBUF-1:0]             mb_arx;
  logic [NBUF-1:0]             mb_arep;
  logic [ID_W-1:0]             gmask;
  logic [ID_W-1:0]             bmask;

  logic [TS_W-1:0]   ts_now;
  logic [NBUF-1:0]   store_vec;
  logic [NBUF-1:0]   reply_vec;
  logic [NBUF-1:0]   done_vec;
  logic [NBUF-1:0]   tx_pend;
  logic [SLOT_W-1:0] store_slot;
  logic [SLOT_W-1:0] acc_slot;
  logic [2:0]        acc_word;
  logic [15:0]       merged;
  logic              unused_bits;

  assign acc_slot = cpu_addr[AW-1:3];
  assign acc_word = cpu_addr[2:0];
  assign merged   = byte_merge(cpu_rdata, cpu_wdata, cpu_be);
  assign unused_bits = ^{merged[15:10], merged[14:13]};

  can_mb_tstamp #(.TS_W(TS_W)) u_ts (.clk(clk), .rst_n(rst_n), .ts_now(ts_now));

  can_mb_accept #(.NBUF(NBUF)) u_acc (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide),
    .rx_rtr(rx_rtr), .mb_id(mb_id), .mb_ide(mb_ide), .mb_dir(mb_dir), .mb_state(mb_state),
    .mb_arep(mb_arep), .gmask(gmask), .bmask(bmask), .store_vec(store_vec),
    .store_slot(store_slot), .reply_vec(reply_vec));

  for (genvar g = 0; g < NBUF; g++) begin : g_pend
    assign tx_pend[g] = mb_dir[g] && (mb_state[g] == MB_TXREQ);
  end

  can_mb_txarb #(.NBUF(NBUF)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(tx_pend), .prio(mb_prio), .valid(tx_valid), .slot(tx_slot));

  assign tx_id    = mb_id[tx_slot];
  assign tx_ide   = mb_ide[tx_slot];
  assign tx_rtr   = mb_rtr[tx_slot];
  assign tx_data  = mb_data[tx_slot];
  assign done_vec = (tx_done && tx_valid) ? (NBUF'(1) << tx_slot) : '0;

  // combinational register read
  always_comb begin
    cpu_rdata = '0;
    if (acc_slot == SLOT_W'(GLOBAL)) begin
      case (acc_word)
        3'd0: cpu_rdata = gmask[15:0];
        3'd1: cpu_rdata = {3'b000, gmask[ID_W-1:16]};
        3'd2: cpu_rdata = bmask[15:0];
        3'd3: cpu_rdata = {3'b000, bmask[ID_W-1:16]};
        3'd4: cpu_rdata = 16'(ts_now);
        default: cpu_rdata = '0;
      endcase
    end else if (acc_slot < SLOT_W'(NBUF)) begin
      case (acc_word)
        3'd0: cpu_rdata = mb_id[acc_slot][15:0];
        3'd1: cpu_rdata = {mb_ide[acc_slot], 2'b00, mb_id[acc_slot][ID_W-1:16]};
        3'd2: cpu_rdata = mb_data[acc_slot][15:0];
        3'd3: cpu_rdata = mb_data[acc_slot][31:16];
        3'd4: cpu_rdata = 16'(mb_ts[acc_slot]);
        3'd5: cpu_rdata = {6'b0, mb_arep[acc_slot], mb_arx[acc_slot], mb_prio[acc_slot],
                           mb_rtr[acc_slot], mb_dir[acc_slot], mb_state[acc_slot]};
        default: cpu_rdata = '0;
      endcase
    end
  end

  // buffer storage: CPU writes first, bus events take precedence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_id <= '0; mb_ide <= '0; mb_data <= '0; mb_ts <= '0; mb_state <= '0;
      mb_dir <= '0; mb_rtr <= '0; mb_prio <= '0; mb_arx <= '0; mb_arep <= '0;
      gmask <= '1; bmask <= '1;
      rx_stored <= 1'b0; rx_slot <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (cpu_wr && acc_slot == SLOT_W'(i)) begin
          case (acc_word)
            3'd0: mb_id[i][15:0] <= merged;
            3'd1: begin
              mb_id[i][ID_W-1:16] <= merged[12:0];
              mb_ide[i]           <= merged[15];
            end
            3'd2: mb_data[i][15:0]  <= merged;
            3'd3: mb_data[i][31:16] <= merged;
            3'd5: begin
              mb_state[i] <= merged[1:0];
              mb_dir[i]   <= merged[2];
              mb_rtr[i]   <= merged[3];
              mb_prio[i]  <= merged[7:4];
              mb_arx[i]   <= merged[8];
              mb_arep[i]  <= merged[9];
            end
            default: ;
          endcase
        end
        if (store_vec[i]) begin
          mb_id[i]    <= rx_id;
          mb_ide[i]   <= rx_ide;
          mb_data[i]  <= rx_data;
          mb_rtr[i]   <= rx_rtr;
          mb_state[i] <= MB_FULL;
          mb_ts[i]    <= ts_now;
        end
        if (reply_vec[i]) mb_state[i] <= MB_TXREQ;
        if (done_vec[i]) begin
          mb_state[i] <= MB_EMPTY;
          mb_ts[i]    <= ts_now;
          if (mb_rtr[i] && mb_arx[i]) mb_dir[i] <= 1'b0;
        end
      end
      if (cpu_wr && acc_slot == SLOT_W'(GLOBAL)) begin
        case (acc_word)
          3'd0: gmask[15:0]      <= merged;
          3'd1: gmask[ID_W-1:16] <= merged[12:0];
          3'd2: bmask[15:0]      <= merged;
          3'd3: bmask[ID_W-1:16] <= merged[12:0];
          default: ;
        endcase
      end
      rx_stored <= |store_vec;
      rx_slot   <= store_slot;
    end
  end

  AST_STORED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stored |-> (mb_state[rx_slot] == MB_FULL) && !mb_dir[rx_slot]); // R7
  AST_TX_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> mb_dir[tx_slot] && (mb_state[tx_slot] == MB_TXREQ)); // R9
  AST_TXDONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_valid) |=> mb_state[$past(tx_slot)] == MB_EMPTY); // R10
  AST_REPLY_NOSTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (|reply_vec) |=> !rx_stored); // R12
endmodule

// File: tb/can_mb_top_tb.sv
module can_mb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_be = 2'b11;
  logic [6:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        rx_valid = 1'b0;
  logic [28:0] rx_id = '0;
  logic        rx_ide = 1'b0;
  logic        rx_rtr = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_stored;
  logic [3:0]  rx_slot;
  logic        tx_valid;
  logic [3:0]  tx_slot;
  logic [28:0] tx_id;
  logic        tx_ide;
  logic        tx_rtr;
  logic [31:0] tx_data;
  logic        tx_done = 1'b0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  can_mb_top dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_be(cpu_be), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rx_valid(rx_valid), .rx_id(rx_id),
    .rx_ide(rx_ide), .rx_rtr(rx_rtr), .rx_data(rx_data), .rx_stored(rx_stored),
    .rx_slot(rx_slot), .tx_valid(tx_valid), .tx_slot(tx_slot), .tx_id(tx_id),
    .tx_ide(tx_ide), .tx_rtr(tx_rtr), .tx_data(tx_data), .tx_done(tx_done));

  // {ide, id, expect_store, expect_slot}
  localparam logic [34:0] VEC [8] = '{
    {1'b0, 29'h0000125, 1'b1, 4'd0},
    {1'b0, 29'h000012F, 1'b1, 4'd0},
    {1'b0, 29'h0000130, 1'b1, 4'd14},
    {1'b1, 29'h1ABCDE07, 1'b1, 4'd2},
    {1'b1, 29'h1ABCDF00, 1'b0, 4'd0},
    {1'b0, 29'h00007FF, 1'b1, 4'd14},
    {1'b1, 29'h0000120, 1'b0, 4'd0},
    {1'b0, 29'h10000120, 1'b1, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int slot, input int word, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    cpu_addr = 7'(slot * 8 + word); cpu_be = be; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input int slot, input int word, output logic [15:0] v);
    @(negedge clk);
    cpu_addr = 7'(slot * 8 + word);
    #1 v = cpu_rdata;
  endtask

  task automatic send(input logic [28:0] id, input logic ide, input logic rtr, input logic [31:0] d,
                      output logic st, output logic [3:0] sl, output logic [15:0] ts);
    @(negedge clk);
    cpu_addr = 7'(15 * 8 + 4);
    rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_data = d; rx_valid = 1'b1;
    #1 ts = cpu_rdata;
    @(posedge clk);
    #1 st = rx_stored; sl = rx_slot;
    @(negedge clk);
    rx_valid = 1'b0; rx_rtr = 1'b0;
  endtask

  task automatic finish_tx(output logic [15:0] ts);
    @(negedge clk);
    cpu_addr = 7'(15 * 8 + 4);
    tx_done = 1'b1;
    #1 ts = cpu_rdata;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v, ts, ts2;
    logic st;
    logic [3:0] sl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5, 5, v);  chk("R1 ctrl", 32'(v), 32'h0);
    rd(3, 0, v);  chk("R1 id", 32'(v), 32'h0);
    rd(15, 0, v); chk("R1 gmask lo", 32'(v), 32'hFFFF);
    rd(15, 1, v); chk("R1 gmask hi", 32'(v), 32'h1FFF);
    rd(15, 3, v); chk("R1 bmask hi", 32'(v), 32'h1FFF);
    chk("R1 tx_valid", 32'(tx_valid), 32'h0);
    chk("R1 rx_stored", 32'(rx_stored), 32'h0);

    // R2 byte enables
    wr(13, 2, 2'b11, 16'h1234);
    wr(13, 2, 2'b10, 16'hAB99);
    rd(13, 2, v); chk("R2 high byte only", 32'(v), 32'hAB34);
    wr(13, 2, 2'b01, 16'h5566);
    rd(13, 2, v); chk("R2 low byte only", 32'(v), 32'hAB66);

    // setup: masks and buffers
    wr(15, 0, 2'b11, 16'hFFF0);
    wr(15, 2, 2'b11, 16'h0000);
    wr(15, 3, 2'b11, 16'h0000);
    wr(0, 0, 2'b11, 16'h0120);
    wr(1, 0, 2'b11, 16'h0120);
    wr(2, 0, 2'b11, 16'hDE00);
    wr(2, 1, 2'b11, 16'h9ABC);          // ide=1, id[28:16]=1ABC
    for (int b = 3; b < 14; b++) wr(b, 5, 2'b11, 16'h0004);   // R3 direction bit: transmit idle
    rd(2, 1, v); chk("R2 id hi word", 32'(v), 32'h9ABC);

    // acceptance table: R4 R5 R6
    for (int k = 0; k < 8; k++) begin
      send(VEC[k][33:5], VEC[k][34], 1'b0, 32'(k) * 32'h01010101, st, sl, ts);
      chk($sformatf("R4 vec%0d stored", k), 32'(st), 32'(VEC[k][4]));
      if (VEC[k][4]) begin
        chk($sformatf("R5 vec%0d slot", k), 32'(sl), 32'(VEC[k][3:0]));
        rd(int'(VEC[k][3:0]), 0, v);
        chk($sformatf("R7 vec%0d id", k), 32'(v), 32'(VEC[k][20:5]));
        rd(int'(VEC[k][3:0]), 5, v);
        chk($sformatf("R3 vec%0d state full", k), 32'(v), 32'h1);
        wr(int'(VEC[k][3:0]), 5, 2'b11, 16'h0000);
      end
    end

    // R5 R6 R7 R8 fill order and drop
    send(29'h120, 1'b0, 1'b0, 32'hCAFEF00D, st, sl, ts);
    chk("R5 first to b0", 32'(sl), 32'd0);
    chk("R8 pulse high", 32'(rx_stored), 32'h1);
    @(posedge clk); #1 chk("R8 pulse one cycle", 32'(rx_stored), 32'h0);
    rd(0, 4, v);  chk("R7 stamp", 32'(v), 32'(ts));
    rd(0, 3, v);  chk("R7 data hi", 32'(v), 32'hCAFE);
    send(29'h120, 1'b0, 1'b0, 32'h1, st, sl, ts);
    chk("R5 full skipped", 32'(sl), 32'd1);
    send(29'h120, 1'b0, 1'b0, 32'h2, st, sl, ts);
    chk("R6 basic fallback", 32'(sl), 32'd14);
    send(29'h120, 1'b0, 1'b0, 32'h3, st, sl, ts);
    chk("R7 drop when full", 32'(st), 32'h0);
    rd(14, 2, v); chk("R7 basic not overwritten", 32'(v), 32'h0002);
    wr(0, 5, 2'b11, 16'h0); wr(1, 5, 2'b11, 16'h0); wr(14, 5, 2'b11, 16'h0);

    // R9 R10 arbitration
    wr(7, 0, 2'b11, 16'h0777);
    wr(5, 5, 2'b11, 16'h0036);
    wr(7, 5, 2'b11, 16'h0016);
    wr(9, 5, 2'b11, 16'h0016);
    #1 chk("R9 best prio", 32'(tx_slot), 32'd7);
    chk("R9 tx_id", 32'(tx_id), 32'h777);
    finish_tx(ts);
    rd(7, 5, v);  chk("R10 released", 32'(v), 32'h0014);
    rd(7, 4, v);  chk("R10 stamp", 32'(v), 32'(ts));
    #1 chk("R9 tie next", 32'(tx_slot), 32'd9);
    finish_tx(ts);
    #1 chk("R9 last", 32'(tx_slot), 32'd5);
    finish_tx(ts);
    #1 chk("R10 none left", 32'(tx_valid), 32'h0);

    // R11 revert after remote send
    wr(10, 5, 2'b11, 16'h010E);
    #1 chk("R11 offered", 32'(tx_slot), 32'd10);
    chk("R11 remote flag", 32'(tx_rtr), 32'h1);
    finish_tx(ts);
    rd(10, 5, v); chk("R11 now receiver", 32'(v), 32'h0108);
    send(29'h005, 1'b0, 1'b0, 32'h55, st, sl, ts);
    chk("R11 accepts", 32'(sl), 32'd10);

    // R12 auto reply
    wr(11, 0, 2'b11, 16'h03A0);
    wr(11, 5, 2'b11, 16'h0204);
    send(29'h3A0, 1'b0, 1'b1, 32'h0, st, sl, ts);
    chk("R12 not stored", 32'(st), 32'h0);
    rd(11, 5, v); chk("R12 scheduled", 32'(v), 32'h0206);
    #1 chk("R12 offered", 32'(tx_slot), 32'd11);
    finish_tx(ts);
    send(29'h3A1, 1'b0, 1'b1, 32'h0, st, sl, ts);
    chk("R12 unmatched remote stored", 32'(sl), 32'd14);
    rd(14, 5, v); chk("R12 remote flag kept", 32'(v), 32'h0009);

    // R13 counter
    rd(15, 4, ts);
    repeat (9) @(negedge clk);
    rd(15, 4, ts2);
    chk("R13 step", 32'(ts2 - ts), 32'd10);
    rd(15, 4, ts);
    repeat (65535) @(negedge clk);
    rd(15, 4, ts2);
    chk("R13 wrap", 32'(ts2), 32'(ts));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule